// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block watches two supply comparator flags and a watchdog kick line, and drives a pair of complementary system resets. One flag is high while the supply is above the upper threshold, the other while it is above the lower threshold. Both flags and the kick line arrive already synchronised to `clk`.

One shared timeout counter does two jobs. After power-up, and after any undervoltage event, reset stays asserted until the upper flag is seen. The counter then has to run to its terminal count before reset is released. While the system runs, each rising edge on the kick line clears the counter. If the counter reaches its terminal count first, a reset pulse of fixed width is issued. After the pulse, the block releases reset and tries again with a fresh count. It keeps producing pulses until kicks return.

A drop below the lower threshold asserts reset at once. Counting restarts only after the supply climbs back above the upper threshold, which gives the two thresholds their hysteresis.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: A high `rst` sampled at a rising edge asserts reset (`sys_rst`=1) and clears the counter at that edge. Leaving it takes a full ramp of TIMEOUT cycles once `sup_hi` is high.
- R2: `sys_rst_n` is always the inverse of `sys_rst`.
- R3: While `sup_hi` is low and no run state has been reached, reset stays asserted for any number of cycles and the counter stays at zero.
- R4: If the block is holding and `sup_hi` and `sup_lo` are both sampled high at edge n, the outputs deassert at edge n+TIMEOUT and not before.
- R5: While running, each rising edge of `wd_kick` restarts the timeout. Kick edges spaced at most TIMEOUT cycles apart keep reset deasserted, including when the spacing widens after earlier faster kicks.
- R6: When running, if TIMEOUT edges pass without a kick edge, reset asserts at the TIMEOUT-th edge. It stays asserted for RST_PULSE cycles, then deasserts with the count restarted. This repeats until kicks resume.
- R7: `sup_lo` sampled low at an edge asserts reset at that edge. This holds in every state and regardless of the counter or of `wd_kick`.
- R8: After an undervoltage reset, reset stays asserted while only `sup_lo` is high. A new full TIMEOUT ramp starts only when `sup_hi` returns high. A ramp cut short by undervoltage restarts from zero.
- R9: Kick edges that occur while reset is asserted (ramp or pulse) have no effect. A kick held high across the end of a pulse does not count as a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| sup_hi | input | 1 | Supply above upper threshold |
| sup_lo | input | 1 | Supply above lower threshold |
| wd_kick | input | 1 | Watchdog kick, rising edge counts |
| sys_rst | output | 1 | Reset out, active high, registered |
| sys_rst_n | output | 1 | Reset out, active low, registered |

## Verification
A counter that fails to clear shows up at the ports as a release that comes too early or too late. It also shows up as a watchdog pulse that fires despite kicks spaced exactly TIMEOUT cycles apart. Both errors are visible within one timeout window. A wrong state after undervoltage shows up as a release while only the lower flag is high. A pulse timer that is off by one changes the pulse width by a cycle on the first starvation. The bench predicts each cycle's reset level from the requirements and compares it one edge after the stimulus.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;
  typedef enum logic [1:0] {
    SUP_HOLD  = 2'd0,
    SUP_RAMP  = 2'd1,
    SUP_RUN   = 2'd2,
    SUP_PULSE = 2'd3
  } sup_state_t;
endpackage

// File: rtl/wdt_sup_edge.sv
module wdt_sup_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/wdt_sup_counter.sv
module wdt_sup_counter #(
  parameter int LIMIT = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(LIMIT+1)-1:0]   cnt,
  output logic                         term
);
  localparam int CW = $clog2(LIMIT+1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign term = (cnt == LAST);

  // control must clear before the count passes its terminal value (R6, R4)
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor #(
  parameter int TIMEOUT   = 8,
  parameter int RST_PULSE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_hi,
  input  logic sup_lo,
  input  logic wd_kick,
  output logic sys_rst,
  output logic sys_rst_n
);
  import wdt_sup_pkg::*;

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int PW = $clog2(RST_PULSE + 1);

  sup_state_t st_q, st_d;
  logic          kick_rise;
  logic          tmr_clr, tmr_inc, tmr_term;
  logic          pls_clr, pls_inc, pls_done;
  logic [TW-1:0] tmr_cnt;
  logic [PW-1:0] pls_cnt;

  wdt_sup_edge u_kick (
    .clk (clk), .rst (rst), .din (wd_kick), .rise (kick_rise)
  );

  wdt_sup_counter #(.LIMIT(TIMEOUT)) u_tmr (
    .clk (clk), .rst (rst), .clr (tmr_clr), .inc (tmr_inc),
    .cnt (tmr_cnt), .term (tmr_term)
  );

  wdt_sup_counter #(.LIMIT(RST_PULSE)) u_pls (
    .clk (clk), .rst (rst), .clr (pls_clr), .inc (pls_inc),
    .cnt (pls_cnt), .term (pls_done)
  );

  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    tmr_inc = 1'b0;
    pls_clr = 1'b0;
    pls_inc = 1'b0;
    if (!sup_lo) begin
      st_d    = SUP_HOLD;
      tmr_clr = 1'b1;
      pls_clr = 1'b1;
    end else begin
      case (st_q)
        SUP_HOLD: begin
          tmr_clr = 1'b1;
          if (sup_hi) st_d = SUP_RAMP;
        end
        SUP_RAMP: begin
          if (tmr_term) begin
            st_d    = SUP_RUN;
            tmr_clr = 1'b1;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        SUP_RUN: begin
          if (kick_rise) begin
            tmr_clr = 1'b1;
          end else if (tmr_term) begin
            st_d    = SUP_PULSE;
            tmr_clr = 1'b1;
            pls_clr = 1'b1;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        SUP_PULSE: begin
          if (pls_done) begin
            st_d    = SUP_RUN;
            tmr_clr = 1'b1;
          end else begin
            pls_inc = 1'b1;
          end
        end
        default: st_d = SUP_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SUP_HOLD;
      sys_rst   <= 1'b1;
      sys_rst_n <= 1'b0;
    end else begin
      st_q      <= st_d;
      sys_rst   <= (st_d != SUP_RUN);
      sys_rst_n <= (st_d == SUP_RUN);
    end
  end

  assert_complement_R2: assert property (@(posedge clk) disable iff (rst)
    sys_rst_n == !sys_rst);

  assert_uv_assert_R7: assert property (@(posedge clk) disable iff (rst)
    !sup_lo |=> sys_rst && st_q == SUP_HOLD);

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
    st_q == SUP_HOLD |-> tmr_cnt == '0);

  assert_release_at_term_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == SUP_RAMP && tmr_term && sup_lo) |=> !sys_rst);

  assert_kick_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == SUP_RUN && kick_rise && sup_lo) |=> tmr_cnt == '0 && !sys_rst);

  assert_pulse_held_R6: assert property (@(posedge clk) disable iff (rst)
    st_q == SUP_PULSE |-> sys_rst);

  assert_pulse_no_kick_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SUP_PULSE && !pls_done && sup_lo) |=> st_q == SUP_PULSE);
endmodule

// File: tb/wdt_reset_supervisor_bench.sv
module wdt_reset_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 8;
  localparam int PL = 3;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_hi = 1'b0;
  logic sup_lo = 1'b0;
  logic wd_kick = 1'b0;
  logic sys_rst, sys_rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reset_supervisor #(.TIMEOUT(TO), .RST_PULSE(PL)) u_wdt_reset_supervisor (
    .clk (clk), .rst (rst), .sup_hi (sup_hi), .sup_lo (sup_lo),
    .wd_kick (wd_kick), .sys_rst (sys_rst), .sys_rst_n (sys_rst_n)
  );

  task automatic cyc(input logic p, input logic vh, input logic vl,
                     input logic k, input logic e, input string t);
    item_t it;
    @(negedge clk);
    rst = p; sup_hi = vh; sup_lo = vl; wd_kick = k;
    it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  // monitor: compares one expected item per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (sys_rst !== it.exp) begin
          errors++;
          $display("FAIL %s: sys_rst=%0b expected %0b at %0t", it.tag, sys_rst, it.exp, $time);
        end
        checks++;
        if (sys_rst_n !== !it.exp) begin
          errors++;
          $display("FAIL R2: sys_rst_n=%0b expected %0b at %0t", sys_rst_n, !it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: power-on reset
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, 1, "R1");
    // R3: only lower flag high, no ramp
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, 1, "R3");
    // R4: ramp of exactly TO edges
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, 0, 1, "R4");
    cyc(0, 1, 1, 0, 0, "R4");
    // R5: fast kicks then slower kicks at the TO limit
    for (int i = 0; i < 12; i++) cyc(0, 1, 1, (i % 3) == 0, 0, "R5");
    for (int i = 0; i < 17; i++) cyc(0, 1, 1, (i % TO) == 0, 0, "R5");
    // R6: starvation -> pulse, then retry and pulse again
    for (int i = 0; i < TO - 1; i++) cyc(0, 1, 1, 0, 0, "R6");
    for (int i = 0; i < PL; i++) cyc(0, 1, 1, 0, 1, "R6");
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, 0, 0, "R6");
    // R9: kick rising inside a pulse and held high is ignored
    cyc(0, 1, 1, 0, 1, "R9");
    cyc(0, 1, 1, 1, 1, "R9");
    cyc(0, 1, 1, 1, 1, "R9");
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, 1, 0, "R9");
    for (int i = 0; i < PL; i++) cyc(0, 1, 1, 1, 1, "R9");
    // R6: kicks resume, reset stays released
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, (i % 4) == 2, 0, "R6");
    // R7: undervoltage with a simultaneous kick edge
    cyc(0, 0, 0, 1, 1, "R7");
    // R8: hysteresis, lower flag alone does not restart
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, 1, "R8");
    // R9: kicks during ramp ignored, release on time (R4)
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, i % 2, 1, "R9");
    cyc(0, 1, 1, 0, 0, "R4");
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, (i % 3) == 1, 0, "R5");
    // R7/R8: undervoltage mid ramp, ramp restarts from zero
    cyc(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 1, "R8");
    cyc(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1, "R8");
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, 0, 1, "R8");
    cyc(0, 1, 1, 0, 0, "R8");
    // R1: power-on reset while running forces a full ramp
    cyc(1, 1, 1, 0, 1, "R1");
    for (int i = 0; i < TO; i++) cyc(0, 1, 1, 0, 1, "R1");
    cyc(0, 1, 1, 0, 0, "R1");
    // R7: undervoltage during a watchdog pulse holds past pulse end
    for (int i = 0; i < TO - 1; i++) cyc(0, 1, 1, 0, 0, "R6");
    cyc(0, 1, 1, 0, 1, "R6");
    cyc(0, 0, 0, 0, 1, "R7");
    for (int i = 0; i < PL + 1; i++) cyc(0, 0, 1, 0, 1, "R8");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule